// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing reference of a two-output PWM unit. A 16-bit counter advances once per divided tick. It counts up and wraps, counts down and reloads, or counts up and then down in a triangle. The limit of the count is a programmable period. Two one-clock strobes, one for "counter reached zero" and one for "counter reached the period", go to the downstream action logic. That logic turns them into output edges.

Software programs the block through a small write port. A control word sets the count direction, how the counter stops or runs, the two-stage clock divider and whether period writes take effect at once or are staged. The counter advances only on `tick_en` pulses, after those pulses have been divided by the programmed ratio.

Top module: `pwm_timebase`

## Requirements
- R1: After reset every register is cleared and the counter is 0 with both strobes low. The run field then reads 00, so the counter stays at 0 while `tick_en` pulses arrive.
- R2: The counter advances once every N `tick_en` pulses. A is control bits 12:10 and B is control bits 9:7. N = 2^A when B = 0, and N = 2^A * 2B otherwise. A write to the control register restarts the divider phase, and the write cycle itself never advances the counter.
- R3: With mode bits 1:0 = 00 the counter steps up from 0 to the active period, then returns to 0. If the counter is already above the period, its next advance goes to 0.
- R4: With mode bits 1:0 = 01 the counter loads the active period when it advances from 0, then steps down to 0.
- R5: With mode bits 1:0 = 10 the counter runs 0, 1, ..., P, P-1, ..., 1, 0 and repeats, changing direction at the period and at 0.
- R6: With mode bits 1:0 = 11 the counter holds its value and no strobe is produced. Returning to mode 00 resumes counting from the held value.
- R7: Run bits 15:14 decide whether the counter may advance. With 00 it stops advancing at once. With 01 it keeps advancing until it lands on 0, then holds there. With 10 or 11 it runs without limit.
- R8: The control register is written at address 0x00 and the period at address 0x0A. When control bit 3 is 1, a period write replaces the active period at once.
- R9: When control bit 3 is 0, a period write goes to a staging register. That value becomes active on the advance that takes the counter to 0. A period write in the same cycle as that advance takes effect on that same advance.
- R10: The zero strobe is high for exactly one clock, in the cycle where the counter has just advanced to 0. The period strobe is high for exactly one clock, in the cycle where the counter has just advanced to the active period. Neither strobe fires in any other cycle.
- R11: Clocks in which `tick_en` is low do not count toward the divide ratio.
- R12: Writes to any address other than 0x00 or 0x0A change neither the counting nor the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Register write data |
| tick_en | input | 1 | Pre-divided tick enable |
| cnt_o | output | 16 | Current counter value |
| zero_stb_o | output | 1 | Counter reached zero |
| prd_stb_o | output | 1 | Counter reached the period |

## Verification
Two functions can act on the same clock edge. One is a staged period write arriving from the bus. The other is the zero-reload that moves the staged value into the active period. To provoke the overlap, the bench issues the staged write in the cycle where the counter sits at the period, so the write lands on the wrap edge. The result is judged by the length of the following count cycle and by where the period strobe appears: the new period must apply at once, with no pass at the old limit.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    localparam int CTRL_W      = 16;
    localparam int MODE_LSB    = 0;
    localparam int DIRECT_BIT  = 3;
    localparam int DIVB_LSB    = 7;
    localparam int DIVA_LSB    = 10;
    localparam int RUN_LSB     = 14;
    localparam int DIV_FIELD_W = 3;
    // widest ratio: 2^(2^W-1) * 2*(2^W-1)
    localparam int PRE_W       = (1 << DIV_FIELD_W) - 1 + DIV_FIELD_W + 2;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT     = 2'b00,
        RUN_TO_ZERO  = 2'b01,
        RUN_FREE_ALT = 2'b10,
        RUN_FREE     = 2'b11
    } run_mode_e;

    typedef struct packed {
        run_mode_e              run;
        logic [DIV_FIELD_W-1:0] div_a;
        logic [DIV_FIELD_W-1:0] div_b;
        logic                   prd_direct;
        cnt_mode_e              mode;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.run        = run_mode_e'(w[RUN_LSB +: 2]);
        c.div_a      = w[DIVA_LSB +: DIV_FIELD_W];
        c.div_b      = w[DIVB_LSB +: DIV_FIELD_W];
        c.prd_direct = w[DIRECT_BIT];
        c.mode       = cnt_mode_e'(w[MODE_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] div_ratio(input logic [DIV_FIELD_W-1:0] a,
                                                   input logic [DIV_FIELD_W-1:0] b);
        logic [PRE_W-1:0] hs;
        hs = (b == '0) ? PRE_W'(1) : PRE_W'({b, 1'b0});
        return hs << a;
    endfunction

endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale
    import pwmtb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   restart,
    input  logic [DIV_FIELD_W-1:0] div_a,
    input  logic [DIV_FIELD_W-1:0] div_b,
    output logic                   tb_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_q, st_d;
    logic [PRE_W-1:0] last;

    always_comb begin
        last    = div_ratio(div_a, div_b) - PRE_W'(1);
        st_d    = st_q;
        tb_tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick_en) begin
            if (st_q.cnt >= last) begin
                st_d.cnt = '0;
                tb_tick  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
    import pwmtb_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 6,
    parameter int CTRL_ADDR = 0,
    parameter int PRD_ADDR  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              zero_load,
    output ctrl_t             ctrl,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  prd_act,
    output logic [CNT_W-1:0]  prd_next
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] staged;
        logic [CNT_W-1:0] active;
    } reg_st_t;

    reg_st_t st_q, st_d;
    logic    hit_ctrl;
    logic    hit_prd;
    logic    unused_ctrl_bits;

    assign hit_ctrl         = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign hit_prd          = wr_en && (wr_addr == ADDR_W'(PRD_ADDR));
    assign unused_ctrl_bits = ^{wr_data[13], wr_data[6:4]};

    always_comb begin
        st_d = st_q;
        if (hit_ctrl) begin
            st_d.ctrl = decode_ctrl(wr_data[CTRL_W-1:0]);
        end
        if (hit_prd) begin
            st_d.staged = wr_data;
            if (st_q.ctrl.prd_direct) begin
                st_d.active = wr_data;
            end
        end
        // zero reload forwards a write landing in the same cycle
        if (zero_load) begin
            st_d.active = st_d.staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl     = st_q.ctrl;
    assign ctrl_wr  = hit_ctrl;
    assign prd_act  = st_q.active;
    assign prd_next = st_d.active;

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  cnt_mode_e        mode,
    input  run_mode_e        run,
    input  logic [CNT_W-1:0] prd_act,
    input  logic [CNT_W-1:0] prd_next,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_stb,
    output logic             prd_stb,
    output logic             zero_load
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } ctr_st_t;

    typedef struct packed {
        logic zero;
        logic prd;
    } stb_st_t;

    ctr_st_t st_q, st_d;
    stb_st_t stb_q, stb_d;
    logic    advance;
    logic    may_run;

    always_comb begin
        st_d    = st_q;
        may_run = (run == RUN_FREE) || (run == RUN_FREE_ALT) ||
                  ((run == RUN_TO_ZERO) && (st_q.cnt != '0));
        advance = tb_tick && (mode != CM_HOLD) && may_run;
        if (advance) begin
            unique case (mode)
                CM_UP: begin
                    st_d.down = 1'b0;
                    st_d.cnt  = (st_q.cnt >= prd_act) ? '0 : st_q.cnt + CNT_W'(1);
                end
                CM_DOWN: begin
                    st_d.down = 1'b1;
                    if ((st_q.cnt == '0) || (st_q.cnt > prd_act)) st_d.cnt = prd_act;
                    else                                          st_d.cnt = st_q.cnt - CNT_W'(1);
                end
                CM_UPDN: begin
                    if (prd_act == '0) begin
                        st_d.cnt  = '0;
                        st_d.down = 1'b0;
                    end else if (!st_q.down) begin
                        if (st_q.cnt >= prd_act) begin
                            st_d.cnt  = st_q.cnt - CNT_W'(1);
                            st_d.down = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt  = CNT_W'(1);
                            st_d.down = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_W'(1);
                        end
                    end
                end
                CM_HOLD: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign zero_load = advance && (st_d.cnt == '0);

    always_comb begin
        stb_d.zero = zero_load;
        stb_d.prd  = advance && (st_d.cnt == prd_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            stb_q <= '0;
        end else begin
            st_q  <= st_d;
            stb_q <= stb_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign zero_stb = stb_q.zero;
    assign prd_stb  = stb_q.prd;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmtb_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 6,
    parameter int CTRL_ADDR = 0,
    parameter int PRD_ADDR  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              zero_stb_o,
    output logic              prd_stb_o
);

    ctrl_t            ctrl;
    cnt_mode_e        ctrl_mode;
    run_mode_e        ctrl_run;
    logic             ctrl_wr;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] prd_next;
    logic             tb_tick;
    logic             zero_load;

    assign ctrl_mode = ctrl.mode;
    assign ctrl_run  = ctrl.run;

    pwmtb_regs #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .PRD_ADDR (PRD_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .zero_load(zero_load),
        .ctrl     (ctrl),
        .ctrl_wr  (ctrl_wr),
        .prd_act  (prd_act),
        .prd_next (prd_next)
    );

    pwmtb_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .restart(ctrl_wr),
        .div_a  (ctrl.div_a),
        .div_b  (ctrl.div_b),
        .tb_tick(tb_tick)
    );

    pwmtb_counter #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_tick  (tb_tick),
        .mode     (ctrl_mode),
        .run      (ctrl_run),
        .prd_act  (prd_act),
        .prd_next (prd_next),
        .cnt      (cnt_o),
        .zero_stb (zero_stb_o),
        .prd_stb  (prd_stb_o),
        .zero_load(zero_load)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tb_tick,
    input cnt_mode_e        ctrl_mode,
    input run_mode_e        ctrl_run,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] cnt_o,
    input logic             zero_stb_o,
    input logic             prd_stb_o
);

    a_r10_zero_stb_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_stb_o |-> (cnt_o == '0));

    a_r10_prd_stb_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        prd_stb_o |-> (cnt_o == prd_act));

    a_r10_no_stb_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_tick |=> (!zero_stb_o && !prd_stb_o));

    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode == CM_HOLD) |=> ($stable(cnt_o) && !zero_stb_o && !prd_stb_o));

    a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run == RUN_HALT) |=> ($stable(cnt_o) && !zero_stb_o && !prd_stb_o));

    a_r3_up_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_tick && (ctrl_mode == CM_UP) && (ctrl_run == RUN_FREE) && (cnt_o < prd_act))
        |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_tick   (tb_tick),
    .ctrl_mode (ctrl_mode),
    .ctrl_run  (ctrl_run),
    .prd_act   (prd_act),
    .cnt_o     (cnt_o),
    .zero_stb_o(zero_stb_o),
    .prd_stb_o (prd_stb_o)
);

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;

    localparam int CW = 16;
    localparam int AW = 6;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic          tick_en = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] cnt;
    logic          zs;
    logic          ps;

    int checks   = 0;
    int fails    = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timebase dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tick_en   (tick_en),
        .cnt_o     (cnt),
        .zero_stb_o(zs),
        .prd_stb_o (ps)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input int ec, input bit ez, input bit ep);
        checks++;
        if (int'(cnt) != ec || zs != ez || ps != ep) begin
            fails++;
            $display("FAIL %s actual cnt=%0d zero=%0d prd=%0d expected cnt=%0d zero=%0d prd=%0d",
                     req, cnt, zs, ps, ec, ez, ep);
        end
    endtask

    task automatic st(input string req, input int ec, input bit ez, input bit ep);
        step();
        check_out(req, ec, ez, ep);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = CW'(data);
        step();
        wr_en   = 1'b0;
    endtask

    function automatic int mk_ctrl(input int run, input int a, input int b,
                                   input int direct, input int mode);
        return (run << 14) | (a << 10) | (b << 7) | (direct << 3) | mode;
    endfunction

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic setup(input int mode, input int p, input int run,
                         input int a, input int b, input int direct);
        reset_dut();
        wr(0, mk_ctrl(0, 0, 0, 1, 0));
        wr(10, p);
        wr(0, mk_ctrl(run, a, b, direct, mode));
    endtask

    function automatic int exp_cnt(input int mode, input int p, input int t);
        int pos;
        if (mode == 0) return t % (p + 1);
        if (mode == 1) return (p + 1 - (t % (p + 1))) % (p + 1);
        pos = t % (2 * p);
        return (pos <= p) ? pos : 2 * p - pos;
    endfunction

    task automatic sweep_one(input int mode, input int p, input int a, input int b);
        int    n;
        int    cycles;
        string req;
        n      = (1 << a) * ((b == 0) ? 1 : 2 * b);
        cycles = (2 * p + 2) * n * 2;
        req    = (mode == 0) ? "R3 up (R2 R10)" :
                 (mode == 1) ? "R4 down (R2 R10)" : "R5 updown (R2 R10)";
        setup(mode, p, 3, a, b, 1);
        for (int k = 1; k <= cycles; k++) begin
            int  e;
            bit  adv;
            step();
            adv = (k % n) == 0;
            e   = exp_cnt(mode, p, k / n);
            check_out(req, e, adv && e == 0, adv && e == p);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the run completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, stopped while ticks arrive
        reset_dut();
        for (int i = 0; i < 5; i++) st("R1 reset", 0, 0, 0);

        // R2 R3 R4 R5 R10: sweeps over mode, period and divider
        for (int m = 0; m < 3; m++) begin
            for (int p = 1; p <= 4; p++) begin
                sweep_one(m, p, 0, 0);
                sweep_one(m, p, 1, 0);
                sweep_one(m, p, 0, 1);
                sweep_one(m, p, 0, 2);
                sweep_one(m, p, 1, 1);
                sweep_one(m, p, 2, 3);
            end
        end
        // R2: largest divide ratio
        sweep_one(0, 1, 7, 7);

        // R6: freeze holds, then resumes
        setup(0, 5, 3, 0, 0, 1);
        st("R6 pre", 1, 0, 0);
        st("R6 pre", 2, 0, 0);
        st("R6 pre", 3, 0, 0);
        wr(0, mk_ctrl(3, 0, 0, 1, 3));
        check_out("R6 freeze", 3, 0, 0);
        for (int i = 0; i < 10; i++) st("R6 freeze", 3, 0, 0);
        wr(0, mk_ctrl(3, 0, 0, 1, 0));
        check_out("R6 resume", 3, 0, 0);
        st("R6 resume", 4, 0, 0);
        st("R6 resume", 5, 0, 1);

        // R7: halt at once
        setup(0, 5, 3, 0, 0, 1);
        st("R7 pre", 1, 0, 0);
        st("R7 pre", 2, 0, 0);
        wr(0, mk_ctrl(0, 0, 0, 1, 0));
        check_out("R7 halt", 2, 0, 0);
        for (int i = 0; i < 10; i++) st("R7 halt", 2, 0, 0);

        // R7: run to zero then hold
        setup(0, 5, 3, 0, 0, 1);
        st("R7 pre", 1, 0, 0);
        st("R7 pre", 2, 0, 0);
        wr(0, mk_ctrl(1, 0, 0, 1, 0));
        check_out("R7 to-zero", 2, 0, 0);
        st("R7 to-zero", 3, 0, 0);
        st("R7 to-zero", 4, 0, 0);
        st("R7 to-zero", 5, 0, 1);
        st("R7 to-zero", 0, 1, 0);
        for (int i = 0; i < 8; i++) st("R7 held at zero", 0, 0, 0);

        // R7: run code 10 also runs freely
        setup(0, 3, 2, 0, 0, 1);
        for (int k = 1; k <= 10; k++) st("R7 free alt", k % 4, (k % 4) == 0, (k % 4) == 3);

        // R8: immediate period write below the counter
        setup(0, 6, 3, 0, 0, 1);
        for (int k = 1; k <= 4; k++) st("R8 pre", k, 0, 0);
        wr(10, 2);
        check_out("R8 direct", 5, 0, 0);
        st("R8 direct wrap", 0, 1, 0);
        st("R8 direct", 1, 0, 0);
        st("R8 direct", 2, 0, 1);
        st("R8 direct", 0, 1, 0);

        // R9: staged period applies at the next zero
        setup(0, 3, 3, 0, 0, 0);
        st("R9 pre", 1, 0, 0);
        wr(10, 6);
        check_out("R9 staged", 2, 0, 0);
        st("R9 staged old limit", 3, 0, 1);
        st("R9 staged", 0, 1, 0);
        st("R9 staged", 1, 0, 0);
        st("R9 staged", 2, 0, 0);
        st("R9 staged", 3, 0, 0);
        st("R9 staged", 4, 0, 0);
        st("R9 staged", 5, 0, 0);
        st("R9 staged new limit", 6, 0, 1);
        st("R9 staged", 0, 1, 0);

        // R9: staged write on the wrap edge takes effect there
        setup(0, 3, 3, 0, 0, 0);
        st("R9 pre", 1, 0, 0);
        st("R9 pre", 2, 0, 0);
        st("R9 pre", 3, 0, 1);
        wr(10, 5);
        check_out("R9 collide", 0, 1, 0);
        st("R9 collide", 1, 0, 0);
        st("R9 collide", 2, 0, 0);
        st("R9 collide no old limit", 3, 0, 0);
        st("R9 collide", 4, 0, 0);
        st("R9 collide", 5, 0, 1);
        st("R9 collide", 0, 1, 0);

        // R11: idle tick_en clocks do not count (divide by 2)
        setup(0, 7, 3, 1, 0, 1);
        begin
            int pulses;
            pulses = 0;
            for (int k = 1; k <= 40; k++) begin
                int e;
                bit adv;
                tick_en = (k % 2) == 1;
                step();
                if (tick_en) pulses++;
                adv = tick_en && (pulses % 2) == 0;
                e   = (pulses / 2) % 8;
                check_out("R11 gated ticks", e, adv && e == 0, adv && e == 7);
            end
            tick_en = 1'b1;
        end

        // R12: writes to another address are ignored
        setup(0, 4, 3, 0, 0, 1);
        st("R12 pre", 1, 0, 0);
        st("R12 pre", 2, 0, 0);
        wr(4, 16'hFFFF);
        check_out("R12 ignored", 3, 0, 0);
        for (int i = 1; i <= 10; i++) begin
            int e;
            e = (3 + i) % 5;
            st("R12 ignored", e, e == 0, e == 4);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule